// File: doc/BRIEF.md
# Serial Image Loader and Result Sender

This block links a byte-wide serial receiver and transmitter to a digit recognition engine. Pixel bytes arrive one at a time with a valid strobe. The block packs each row of 29 bytes into one 232-bit word and writes that word into the engine's input memory. Successive rows go to successive addresses, starting at zero. Once the 29th row is stored, the block pulses a start signal for one cycle and waits for the engine to report that it has finished.

When the engine raises done, the block captures the engine's 80-bit score vector, which holds one byte per digit class. It then hands those ten bytes to the transmitter in order, from digit 0 to digit 9. Each byte advances only when the transmitter accepts it. After the tenth byte is accepted, the block is ready to receive the next image. Between the final row write and the final accepted result byte, any pixel bytes that arrive are discarded. Serial bit timing is handled outside this block.

Top module: `pixel_frame_link`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, mem_we_o, start_o and tx_valid_o are low. The first image after reset is written starting at address 0, with its first byte in the lowest byte lane.
- R2: Each group of 29 accepted bytes produces exactly one write cycle. mem_we_o is high for one cycle only, in the cycle that follows the clock edge where the 29th byte was accepted.
- R3: The rows of an image are written to addresses 0, 1, ..., 28, in that order.
- R4: Byte j of a row (j = 0 for the first byte received) sits in mem_data_o bits [8j+7:8j].
- R5: start_o is high for exactly one cycle, in the cycle after the write to address 28.
- R6: Pixel bytes are ignored from the write to address 28 until the tenth result byte is accepted. done_i is ignored in every state except waiting for the engine.
- R7: When done_i is seen while waiting, the block samples result_i, with digit d in bits [8d+7:8d]. From the next cycle, tx_valid_o is high and tx_data_o carries digit 0. The byte on tx_data_o advances to the next digit only on a cycle where tx_ready_i is high, and it stays unchanged while tx_ready_i is low.
- R8: After the tenth accepted result byte, tx_valid_o falls and the next image is written again starting at address 0.
- R9: Changes on result_i after the capture cycle do not alter the bytes that are sent.
- R10: A pixel byte that arrives in the write cycle of rows 0 to 27 is accepted as byte 0 of the next row, so bytes may arrive on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received pixel byte |
| rx_valid_i | input | 1 | rx_data_i holds a new byte |
| mem_addr_o | output | 5 | Row address for the input memory |
| mem_data_o | output | 232 | Packed row word, first byte in the lowest lane |
| mem_we_o | output | 1 | Write strobe for the input memory |
| start_o | output | 1 | One-cycle pulse that starts the engine |
| done_i | input | 1 | Engine has finished; result_i is valid |
| result_i | input | 80 | Score bytes, digit d in bits [8d+7:8d] |
| tx_data_o | output | 8 | Result byte offered to the transmitter |
| tx_valid_o | output | 1 | tx_data_o holds a byte to send |
| tx_ready_i | input | 1 | Transmitter accepts tx_data_o on this cycle |

## Verification
Every output of this block comes from a register, so each response appears in the cycle after the clock edge that caused it. The write strobe follows the edge that accepts the 29th byte. start_o follows the last write by one cycle. tx_valid_o follows the edge where done_i is seen. Each tx_data_o step follows an edge on which tx_ready_i was high. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge. It compares every output against that model on the next falling edge, so every comparison falls in the cycle where the response is due. The stimulus includes gapped and back-to-back pixel streams, stray bytes and early done pulses, a stalling ready pattern, and a result vector that changes after capture.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
  typedef enum logic [2:0] {
    ST_RECV  = 3'd0,
    ST_WRITE = 3'd1,
    ST_START = 3'd2,
    ST_WAIT  = 3'd3,
    ST_SEND  = 3'd4
  } pfl_state_e;
endpackage

// File: rtl/pfl_row_packer.sv
module pfl_row_packer #(
  parameter int BYTE_W    = 8,
  parameter int ROW_BYTES = 29,
  localparam int WORD_W   = BYTE_W * ROW_BYTES,
  localparam int CNT_W    = $clog2(ROW_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [WORD_W-1:0] word_o,
  output logic              row_full_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last    = (cnt_q == CNT_W'(ROW_BYTES - 1));
  assign row_full_o = take_i & at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (take_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  // one lane register per byte position
  for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        word_o[g*BYTE_W +: BYTE_W] <= '0;
      else if (take_i && cnt_q == CNT_W'(g))
        word_o[g*BYTE_W +: BYTE_W] <= byte_i;
    end
  end

  AST_LANE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(ROW_BYTES)); // R2
  AST_WRAP_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_full_o |=> cnt_q == '0); // R2
endmodule

// File: rtl/pfl_result_sender.sv
module pfl_result_sender #(
  parameter int BYTE_W     = 8,
  parameter int NUM_DIGITS = 10,
  localparam int RES_W     = BYTE_W * NUM_DIGITS,
  localparam int IDX_W     = $clog2(NUM_DIGITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [RES_W-1:0]  vec_i,
  input  logic              active_i,
  input  logic              tx_ready_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              last_o
);
  logic [RES_W-1:0]  res_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] lane [NUM_DIGITS];
  logic              fire;

  assign fire   = active_i & tx_ready_i;
  assign last_o = fire & (idx_q == IDX_W'(NUM_DIGITS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      res_q <= vec_i;
      idx_q <= '0;
    end else if (fire) begin
      idx_q <= last_o ? '0 : idx_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_sel
    assign lane[g] = res_q[g*BYTE_W +: BYTE_W];
  end

  assign tx_data_o = lane[idx_q];

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tx_ready_i) |=> $stable(tx_data_o)); // R7
  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < IDX_W'(NUM_DIGITS)); // R7
endmodule

// File: rtl/pixel_frame_link.sv
module pixel_frame_link #(
  parameter int BYTE_W     = 8,
  parameter int ROW_BYTES  = 29,
  parameter int ROWS       = 29,
  parameter int NUM_DIGITS = 10,
  localparam int WORD_W    = BYTE_W * ROW_BYTES,
  localparam int ADDR_W    = $clog2(ROWS),
  localparam int RES_W     = BYTE_W * NUM_DIGITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              mem_we_o,
  output logic              start_o,
  input  logic              done_i,
  input  logic [RES_W-1:0]  result_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  import pfl_pkg::*;

  pfl_state_e        state_q, state_d;
  logic [ADDR_W-1:0] row_q;
  logic              last_row, take, row_full, load_res, sent_all;

  assign last_row = (row_q == ADDR_W'(ROWS - 1));
  // a byte landing in a write cycle belongs to the next row, unless the image is complete
  assign take     = rx_valid_i &&
                    (state_q == ST_RECV || (state_q == ST_WRITE && !last_row));
  assign load_res = (state_q == ST_WAIT) && done_i;

  pfl_row_packer #(
    .BYTE_W    (BYTE_W),
    .ROW_BYTES (ROW_BYTES)
  ) u_packer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .byte_i     (rx_data_i),
    .word_o     (mem_data_o),
    .row_full_o (row_full)
  );

  pfl_result_sender #(
    .BYTE_W     (BYTE_W),
    .NUM_DIGITS (NUM_DIGITS)
  ) u_sender (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_res),
    .vec_i      (result_i),
    .active_i   (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .tx_data_o  (tx_data_o),
    .last_o     (sent_all)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RECV:  if (row_full) state_d = ST_WRITE;
      ST_WRITE: state_d = last_row ? ST_START : ST_RECV;
      ST_START: state_d = ST_WAIT;
      ST_WAIT:  if (done_i) state_d = ST_SEND;
      ST_SEND:  if (sent_all) state_d = ST_RECV;
      default:  state_d = ST_RECV;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RECV;
      row_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WRITE) row_q <= last_row ? '0 : row_q + 1'b1;
    end
  end

  assign mem_we_o   = (state_q == ST_WRITE);
  assign mem_addr_o = row_q;
  assign start_o    = (state_q == ST_START);
  assign tx_valid_o = (state_q == ST_SEND);

  AST_WE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o); // R2
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_addr_o < ADDR_W'(ROWS)); // R3
  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o != ADDR_W'(ROWS - 1)) |=> mem_addr_o == $past(mem_addr_o) + 1'b1); // R3
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o); // R5
  AST_START_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == ADDR_W'(ROWS - 1)) |=> start_o); // R5
  AST_DONE_TO_SEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(start_o) || !tx_valid_o) && load_res |=> tx_valid_o); // R7
  AST_SEND_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sent_all |=> !tx_valid_o && mem_addr_o == '0); // R8
endmodule

// File: tb/pixel_frame_link_tb_top.sv
module pixel_frame_link_tb_top;
  localparam int BW = 8, RB = 29, NR = 29, ND = 10;
  localparam int WW = BW * RB;

  logic           clk_i  = 1'b0;
  logic           rst_ni = 1'b0;
  logic [BW-1:0]  rx_data_i  = '0;
  logic           rx_valid_i = 1'b0;
  logic           done_i     = 1'b0;
  logic [BW*ND-1:0] result_i = '0;
  logic           tx_ready_i = 1'b0;
  logic [4:0]     mem_addr_o;
  logic [WW-1:0]  mem_data_o;
  logic           mem_we_o, start_o, tx_valid_o;
  logic [BW-1:0]  tx_data_o;

  always #5 clk_i = ~clk_i;

  pixel_frame_link dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_data_i(rx_data_i), .rx_valid_i(rx_valid_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .mem_we_o(mem_we_o),
    .start_o(start_o), .done_i(done_i), .result_i(result_i),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i)
  );

  int total = 0, bad = 0, wr_cnt = 0, start_cnt = 0;
  bit fin = 0;
  string ctx = "R1";

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] act=%0h exp=%0h", tag, ctx, act, exp);
    end
  endtask

  // behavioural reference: 0 collect, 1 write, 2 start, 3 wait, 4 send
  int m_ph = 0, m_row = 0, m_sidx = 0;
  logic [BW-1:0] pix_q[$];
  logic [WW-1:0] m_word = '0;
  logic [BW*ND-1:0] m_res = '0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph = 0; m_row = 0; m_sidx = 0; pix_q.delete();
    end else begin
      case (m_ph)
        0: if (rx_valid_i) begin
             pix_q.push_back(rx_data_i);
             if (pix_q.size() == RB) begin
               for (int j = 0; j < RB; j++) m_word[j*BW +: BW] = pix_q[j];
               pix_q.delete();
               m_ph = 1;
             end
           end
        1: begin
             if (rx_valid_i && m_row != NR - 1) pix_q.push_back(rx_data_i);
             if (m_row == NR - 1) begin m_ph = 2; m_row = 0; end
             else begin m_ph = 0; m_row++; end
           end
        2: m_ph = 3;
        3: if (done_i) begin m_res = result_i; m_sidx = 0; m_ph = 4; end
        default: if (tx_ready_i) begin
             m_sidx++;
             if (m_sidx == ND) begin m_sidx = 0; m_ph = 0; end
           end
      endcase
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !fin) begin
      chk(mem_we_o == (m_ph == 1), "R2 write strobe", mem_we_o, m_ph == 1);
      if (m_ph == 1) begin
        chk(mem_addr_o == 5'(m_row), "R3 address", mem_addr_o, m_row);
        chk(mem_data_o == m_word, "R4 packed word", mem_data_o, m_word);
      end
      chk(start_o == (m_ph == 2), "R5 start", start_o, m_ph == 2);
      chk(tx_valid_o == (m_ph == 4), "R7 tx valid", tx_valid_o, m_ph == 4);
      if (m_ph == 4)
        chk(tx_data_o == m_res[m_sidx*BW +: BW], "R7 tx byte", tx_data_o, m_res[m_sidx*BW +: BW]);
      if (mem_we_o) wr_cnt++;
      if (start_o) start_cnt++;
    end
  end

  function automatic logic [7:0] pix(input int seed, input int r, input int c);
    return 8'((seed + r * 31 + c * 7 + r * c) & 255);
  endfunction

  task automatic send_image(input int seed, input bit b2b);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < RB; c++) begin
        rx_data_i = pix(seed, r, c); rx_valid_i = 1'b1;
        @(negedge clk_i);
        if (!b2b) begin rx_valid_i = 1'b0; @(negedge clk_i); end
      end
    rx_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs idle under reset
    chk(!mem_we_o && !start_o && !tx_valid_o, "R1 reset outputs", {mem_we_o, start_o, tx_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!mem_we_o && !start_o && !tx_valid_o, "R1 after release", {mem_we_o, start_o, tx_valid_o}, 0);

    // R6: early done must be ignored
    ctx = "R6 early done";
    done_i = 1'b1; @(negedge clk_i); done_i = 1'b0; @(negedge clk_i);

    ctx = "R1 R4 gapped image";
    send_image(3, 1'b0);
    while (!start_o) @(negedge clk_i);
    @(negedge clk_i);
    ctx = "R6 stray while waiting";
    for (int k = 0; k < 4; k++) begin
      rx_data_i = 8'(8'hA0 + k); rx_valid_i = 1'b1; @(negedge clk_i);
    end
    rx_valid_i = 1'b0;
    ctx = "R9 capture";
    result_i = 80'h0908_0706_0504_0302_0100;
    done_i = 1'b1; @(negedge clk_i);
    done_i = 1'b0; result_i = ~result_i;
    ctx = "R7 R6 stalled send";
    for (int cyc = 0; tx_valid_o; cyc++) begin
      tx_ready_i = (cyc % 3) != 1;
      rx_data_i = 8'(cyc); rx_valid_i = 1'b1;
      @(negedge clk_i);
    end
    rx_valid_i = 1'b0; tx_ready_i = 1'b0;
    chk(wr_cnt == NR, "R6 writes per image", wr_cnt, NR);
    chk(start_cnt == 1, "R5 start count", start_cnt, 1);

    ctx = "R8 R10 back-to-back image";
    send_image(77, 1'b1);
    while (!start_o) @(negedge clk_i);
    @(negedge clk_i);
    result_i = 80'hF1E2_D3C4_B5A6_9788_7F60;
    done_i = 1'b1; @(negedge clk_i);
    @(negedge clk_i);  // done held into send: ignored (R6)
    done_i = 1'b0; tx_ready_i = 1'b1;
    while (tx_valid_o) @(negedge clk_i);
    tx_ready_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk(wr_cnt == 2 * NR, "R8 writes second image", wr_cnt, 2 * NR);
    chk(start_cnt == 2, "R8 start count", start_cnt, 2);
    chk(!tx_valid_o && !mem_we_o, "R8 idle after send", {tx_valid_o, mem_we_o}, 0);
    finish_run();
  end
endmodule